// File: doc/BRIEF.md
# DMA Event and Interrupt Status Unit

This block gathers the completion and fault events of a multi-channel DMA controller and presents them to software as a small set of word registers on a simple synchronous bus. Every channel engine raises a one-cycle pulse on its completion line or on one of four fault lines: burst timeout, request timeout, transfer error and buffer overflow. Each pulse latches a sticky bit that stays set until software clears it by writing a one to that bit.

Two interrupt lines leave the block. The completion interrupt can be masked per channel through a mask register. The fault interrupt cannot be masked and stays high while any fault bit is set. A control register holds the module enable and a self-clearing soft reset. A separate register holds the burst-timeout enable and its count, which the channel engines use.

Top module: `dma_evt_status`

## Requirements
- R1: Registers are selected by byte offset `bus_addr` with `bus_sel` high: 0x00 control (bit 0 enable, bit 1 soft reset), 0x04 completion status, 0x08 mask, 0x0C burst-timeout faults, 0x10 request-timeout faults, 0x14 transfer-error faults, 0x18 buffer-overflow faults, 0x1C timeout control. `bus_rdata` is combinational. Unused bits and unmapped offsets (including 0x20 and above) read 0.
- R2: After `rst_n` is asserted, all status and fault bits are 0, all mask bits are 1, the module is disabled, and the timeout control register is 0.
- R3: Writing the completion status register or a fault register clears each bit written as 1 and keeps each bit written as 0.
- R4: While the module is enabled, a pulse on bit i of an event input sets bit i of the matching register, and that bit is visible from the next cycle on.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Event pulses arriving while the module is disabled change no register.
- R7: `irq_done` is high exactly when some channel has its completion bit set and its mask bit 0. The mask register is written directly, with no clear semantics.
- R8: `irq_err` is high exactly when any bit of the four fault registers is set, whatever the mask holds.
- R9: Writing 1 to control bit 1 makes that bit read back as 1 for one cycle. At the next edge, every register returns to its R2 value and the bit clears itself. A write or event in that cycle is discarded.
- R10: Offset 0x1C bit 15 drives `tmo_en` and bits 14:0 drive `tmo_count`. Control bit 0 drives `mod_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt_done | input | 16 | Completion pulses, bit per channel |
| evt_btmo | input | 16 | Burst-timeout pulses |
| evt_rtmo | input | 16 | Request-timeout pulses |
| evt_xerr | input | 16 | Transfer-error pulses |
| evt_ovf | input | 16 | Buffer-overflow pulses |
| irq_done | output | 1 | Masked completion interrupt |
| irq_err | output | 1 | Unmaskable fault interrupt |
| mod_en | output | 1 | Module enable |
| tmo_en | output | 1 | Burst-timeout enable |
| tmo_count | output | 15 | Burst-timeout count |

## Verification
The bench aims at the same-cycle collision of an event pulse and a one-bit clear. A design that lets the clear win there would silently lose a completion. It drives pulses while the module is disabled and while the soft reset is pending; a design that latched them would raise a spurious interrupt. It sets fault bits under an all-ones mask, where a design that wrongly gated faults by the mask would keep `irq_err` low. It also checks that writing zeros leaves bits intact, since a design with plain write semantics would wipe other channels' status.

// File: rtl/dma_evt_status.sv
module dma_evt_status #(
  parameter int NCH   = 16,
  parameter int TMO_W = 15,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NCH-1:0]   evt_done,
  input  logic [NCH-1:0]   evt_btmo,
  input  logic [NCH-1:0]   evt_rtmo,
  input  logic [NCH-1:0]   evt_xerr,
  input  logic [NCH-1:0]   evt_ovf,
  output logic             irq_done,
  output logic             irq_err,
  output logic             mod_en,
  output logic             tmo_en,
  output logic [TMO_W-1:0] tmo_count
);
  localparam int NERR = 4;
  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_DONE = 3'd1;
  localparam logic [2:0] A_MASK = 3'd2;
  localparam logic [2:0] A_ERR0 = 3'd3;
  localparam logic [2:0] A_TMO  = 3'd7;

  logic             en_q, rst_pend, tmo_en_q;
  logic [TMO_W-1:0] tmo_cnt_q;
  logic [NCH-1:0]   stat_done, mask_q;
  logic [NCH-1:0]   err_q   [NERR];
  logic [NCH-1:0]   err_evt [NERR];

  wire       hit   = bus_sel && (bus_addr[AW-1:5] == '0);
  wire [2:0] widx  = bus_addr[4:2];
  wire       wr_en = hit && bus_wr;
  wire [NCH-1:0] gate = {NCH{en_q}};

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:NCH], bus_addr[1:0]};

  assign err_evt[0] = evt_btmo;
  assign err_evt[1] = evt_rtmo;
  assign err_evt[2] = evt_xerr;
  assign err_evt[3] = evt_ovf;

  function automatic logic [NCH-1:0] clr_for(input logic [2:0] idx);
    return (wr_en && widx == idx) ? bus_wdata[NCH-1:0] : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rst_pend  <= 1'b0;
      tmo_en_q  <= 1'b0;
      tmo_cnt_q <= '0;
      stat_done <= '0;
      mask_q    <= '1;
      for (int k = 0; k < NERR; k++) err_q[k] <= '0;
    end else if (rst_pend) begin
      en_q      <= 1'b0;
      rst_pend  <= 1'b0;
      tmo_en_q  <= 1'b0;
      tmo_cnt_q <= '0;
      stat_done <= '0;
      mask_q    <= '1;
      for (int k = 0; k < NERR; k++) err_q[k] <= '0;
    end else begin
      stat_done <= (stat_done & ~clr_for(A_DONE)) | (evt_done & gate);
      for (int k = 0; k < NERR; k++)
        err_q[k] <= (err_q[k] & ~clr_for(A_ERR0 + 3'(k))) | (err_evt[k] & gate);
      if (wr_en && widx == A_MASK) mask_q <= bus_wdata[NCH-1:0];
      if (wr_en && widx == A_CTL) begin
        en_q     <= bus_wdata[0];
        rst_pend <= bus_wdata[1];
      end
      if (wr_en && widx == A_TMO) begin
        tmo_en_q  <= bus_wdata[TMO_W];
        tmo_cnt_q <= bus_wdata[TMO_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (widx)
        A_CTL:   bus_rdata = 32'({rst_pend, en_q});
        A_DONE:  bus_rdata = 32'(stat_done);
        A_MASK:  bus_rdata = 32'(mask_q);
        3'd3:    bus_rdata = 32'(err_q[0]);
        3'd4:    bus_rdata = 32'(err_q[1]);
        3'd5:    bus_rdata = 32'(err_q[2]);
        3'd6:    bus_rdata = 32'(err_q[3]);
        default: bus_rdata = 32'({tmo_en_q, tmo_cnt_q});
      endcase
    end
  end

  assign irq_done  = |(stat_done & ~mask_q);
  assign irq_err   = |{err_q[0], err_q[1], err_q[2], err_q[3]};
  assign mod_en    = en_q;
  assign tmo_en    = tmo_en_q;
  assign tmo_count = tmo_cnt_q;
endmodule

module dma_evt_status_chk #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [NCH-1:0] evt_done,
  input logic [NCH-1:0] evt_btmo,
  input logic [NCH-1:0] evt_rtmo,
  input logic [NCH-1:0] evt_xerr,
  input logic [NCH-1:0] evt_ovf,
  input logic           irq_err,
  input logic           en_q,
  input logic           rst_pend,
  input logic [NCH-1:0] stat_done,
  input logic [NCH-1:0] mask_q
);
  wire any_err_evt = |{evt_btmo, evt_rtmo, evt_xerr, evt_ovf};
  wire done_wr = bus_sel && bus_wr && bus_addr == 8'h04;

  a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !rst_pend && |evt_done) |=> ((stat_done & $past(evt_done)) == $past(evt_done)));

  a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !rst_pend && !(bus_sel && bus_wr)) |=> (stat_done == $past(stat_done) && !$rose(irq_err)));

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |=> (stat_done == '0 && mask_q == '1 && !en_q && !rst_pend && !irq_err));

  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_err) |-> $past(en_q && any_err_evt));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && !rst_pend) |=> ((stat_done & $past(bus_wdata[NCH-1:0] & ~(evt_done & {NCH{en_q}}))) == '0));
endmodule

bind dma_evt_status dma_evt_status_chk #(.NCH(NCH), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_done(evt_done),
  .evt_btmo(evt_btmo), .evt_rtmo(evt_rtmo), .evt_xerr(evt_xerr),
  .evt_ovf(evt_ovf), .irq_err(irq_err), .en_q(en_q), .rst_pend(rst_pend),
  .stat_done(stat_done), .mask_q(mask_q)
);

// File: tb/test_dma_evt_status.sv
module test_dma_evt_status;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] e_done = 0, e_btmo = 0, e_rtmo = 0, e_xerr = 0, e_ovf = 0;
  logic irq_done, irq_err, mod_en, tmo_en;
  logic [14:0] tmo_count;
  int checks = 0, errors = 0;
  bit running = 0;

  always #10 clk = ~clk;

  dma_evt_status i_dma_evt_status (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_done(e_done), .evt_btmo(e_btmo), .evt_rtmo(e_rtmo),
    .evt_xerr(e_xerr), .evt_ovf(e_ovf), .irq_done(irq_done),
    .irq_err(irq_err), .mod_en(mod_en), .tmo_en(tmo_en), .tmo_count(tmo_count)
  );

  // reference model: index 0 completion, 1..4 fault classes
  logic [15:0] m_reg [5];
  logic [15:0] m_mask;
  bit m_en, m_rst, m_ten;
  int m_tcnt;

  task automatic m_reset();
    for (int k = 0; k < 5; k++) m_reg[k] = 0;
    m_mask = 16'hFFFF; m_en = 0; m_rst = 0; m_ten = 0; m_tcnt = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a >= 8'h20) return 0;
    case (a[4:2])
      0: return {30'd0, m_rst, m_en};
      1: return {16'd0, m_reg[0]};
      2: return {16'd0, m_mask};
      3, 4, 5, 6: return {16'd0, m_reg[a[4:2]-2]};
      default: return {16'd0, m_ten, 15'(m_tcnt)};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      logic [15:0] ev [5];
      bit w;
      ev[0] = e_done; ev[1] = e_btmo; ev[2] = e_rtmo; ev[3] = e_xerr; ev[4] = e_ovf;
      w = bus_sel && bus_wr && bus_addr < 8'h20;
      if (m_rst) m_reset();
      else begin
        for (int k = 0; k < 5; k++) begin
          if (w && bus_addr[4:2] == 3'(k == 0 ? 1 : k + 2)) m_reg[k] &= ~bus_wdata[15:0];
          if (m_en) m_reg[k] |= ev[k];
        end
        if (w && bus_addr[4:2] == 2) m_mask = bus_wdata[15:0];
        if (w && bus_addr[4:2] == 7) begin m_ten = bus_wdata[15]; m_tcnt = int'(bus_wdata[14:0]); end
        if (w && bus_addr[4:2] == 0) begin m_en = bus_wdata[0]; m_rst = bus_wdata[1]; end
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (running && rst_n) begin
      bit eo;
      eo = 0;
      for (int k = 1; k < 5; k++) eo |= (m_reg[k] != 0);
      check("R7 irq_done", 32'(irq_done), 32'((m_reg[0] & ~m_mask) != 0));
      check("R8 irq_err", 32'(irq_err), 32'(eo));
      check("R10 mod_en/tmo", {15'd0, mod_en, tmo_en, tmo_count}, {15'd0, m_en, m_ten, 15'(m_tcnt)});
    end
  end

  task automatic cyc(input bit s, input bit w, input logic [7:0] a, input logic [31:0] d,
                     input logic [15:0] dn, input logic [15:0] bt, input logic [15:0] rt,
                     input logic [15:0] xe, input logic [15:0] ov);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    e_done = dn; e_btmo = bt; e_rtmo = rt; e_xerr = xe; e_ovf = ov;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; e_done = 0; e_btmo = 0; e_rtmo = 0; e_xerr = 0; e_ovf = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #5 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; running = 1;
    // R2 reset values
    rd(8'h00, 0, "R2 ctl"); rd(8'h04, 0, "R2 done"); rd(8'h08, 32'hFFFF, "R2 mask");
    rd(8'h0C, 0, "R2 btmo"); rd(8'h1C, 0, "R2 tmo");
    // R6 disabled drops events
    cyc(0, 0, 0, 0, 16'h00F0, 16'h1, 16'h2, 16'h4, 16'h8);
    rd(8'h04, 0, "R6 done"); rd(8'h18, 0, "R6 ovf");
    // R1 enable
    wr(8'h00, 1); rd(8'h00, 1, "R1 ctl");
    // R4 events set bits
    cyc(0, 0, 0, 0, 16'h8001, 0, 0, 0, 0);
    rd(8'h04, 32'h8001, "R4 done");
    wr(8'h08, 32'h7FFF); rd(8'h08, 32'h7FFF, "R7 mask");
    // R3 clear and write zero
    wr(8'h04, 32'h0001); rd(8'h04, 32'h8000, "R3 clear one");
    wr(8'h04, 0); rd(8'h04, 32'h8000, "R3 zero keeps");
    // R8 faults under full mask
    wr(8'h08, 32'hFFFF);
    cyc(0, 0, 0, 0, 0, 16'h0008, 16'h0020, 16'h0400, 16'h4000);
    rd(8'h0C, 32'h0008, "R8 btmo"); rd(8'h10, 32'h0020, "R8 rtmo");
    rd(8'h14, 32'h0400, "R8 xerr"); rd(8'h18, 32'h4000, "R8 ovf");
    wr(8'h0C, 32'hFFFF); wr(8'h10, 32'h0020); wr(8'h14, 32'h0400);
    rd(8'h18, 32'h4000, "R8 ovf kept"); wr(8'h18, 32'h4000);
    rd(8'h18, 0, "R3 ovf cleared");
    // R5 collision
    cyc(1, 1, 8'h04, 32'h0004, 16'h0004, 0, 0, 0, 0);
    rd(8'h04, 32'h8004, "R5 done collision");
    cyc(1, 1, 8'h14, 32'h0002, 0, 0, 0, 16'h0002, 0);
    rd(8'h14, 32'h0002, "R5 xerr collision");
    // R10 timeout control and R1 unmapped
    wr(8'h1C, 32'hFFFF_8123); rd(8'h1C, 32'h8123, "R10 tmo");
    rd(8'h24, 0, "R1 unmapped"); rd(8'h80, 0, "R1 high offset");
    // R9 soft reset with an event in the pending cycle
    wr(8'h08, 32'h0F0F);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 3;
    @(negedge clk);
    bus_wr = 0; e_done = 16'h0100;
    #5 check("R9 pending bit", bus_rdata, 3);
    @(negedge clk);
    bus_sel = 0; e_done = 0;
    rd(8'h00, 0, "R9 ctl"); rd(8'h04, 0, "R9 done"); rd(8'h08, 32'hFFFF, "R9 mask");
    rd(8'h14, 0, "R9 xerr"); rd(8'h1C, 0, "R9 tmo");
    // mixed traffic against the model
    wr(8'h00, 1);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = 8'({$urandom_range(1, 7), 2'b00});
      d = $urandom;
      if (a == 8'h00) d = {31'd0, d[0]};
      cyc(($urandom % 3) == 0, 1, a, d, 16'($urandom) & 16'($urandom), 16'($urandom) & 16'($urandom) & 16'($urandom),
          16'($urandom) & 16'($urandom) & 16'($urandom), 16'($urandom) & 16'($urandom) & 16'($urandom),
          16'($urandom) & 16'($urandom) & 16'($urandom));
      a = 8'({$urandom_range(0, 7), 2'b00});
      rd(a, m_read(a), "R3 R4 R5 mixed read");
    end
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule